// File: doc/BRIEF.md
# Embedded Controller Host Command Mailbox

This block is the byte-wide mailbox that a host processor uses to talk to an embedded controller. The host reaches it through a small register port with two addresses. The command address reads the status byte and accepts command bytes. The data address reads the output buffer and accepts data bytes. The block keeps one input buffer and one output buffer. A full flag for each buffer tells the host when it may write and when a byte is waiting to be read.

The mailbox decodes three commands. A burst-on command puts the controller in burst mode and answers with a fixed acknowledge byte. A burst-off command leaves burst mode. A query command returns one notification byte. The byte comes from a separate event source, which offers it through a valid/ready handshake. When no event is pending, the answer is zero, which means "nothing outstanding". The block notifies the host through a one-cycle system control interrupt (SCI) pulse on each of these occasions: a byte is placed in the output buffer, burst mode is left, or a new event becomes pending.

Top module: `ec_host_mailbox`

## Requirements
- R1: A command byte 0x82 takes effect two rising edges after the write. At that edge the burst flag (status bit 4) sets, the output buffer holds 0x90, the output-full flag (status bit 0) sets, and `sci` is high for the following cycle.
- R2: A command byte 0x83 clears the burst flag at the same edge where the input-full flag falls, three edges after the write. `sci` is high for the following cycle.
- R3: An accepted write sets the input-full flag (status bit 1) at the next edge. That flag clears two edges later, which is one edge after the byte is consumed. Status bit 3 is 1 when the last accepted byte came through the command address and 0 when it came through the data address.
- R4: A write issued while the input-full flag is set is dropped. It leaves no trace in burst state, in the output buffer or in the flags.
- R5: A read of the command address returns the status byte, with bits 7, 6 and 2 always 0. A read of the data address returns the output buffer and clears the output-full flag at the next edge.
- R6: A command byte 0x84 with an event pending asserts `evt_ready` in the cycle before consumption. At consumption the event code is loaded into the output buffer, the output-full flag sets, the pending flag (status bit 5) clears and `sci` pulses.
- R7: A command byte 0x84 with no event pending loads 0x00 into the output buffer, sets the output-full flag and pulses `sci`. `evt_ready` stays low.
- R8: `evt_valid` raised while no event is pending sets the pending flag (status bit 5) at the next edge, with an `sci` pulse in the following cycle.
- R9: Any other command byte, and any byte written to the data address, is consumed with no effect on burst state, output buffer, output-full flag or `sci`.
- R10: After the active-low synchronous reset, every flag is 0, both buffers hold 0x00 and `sci` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_is_cmd | input | 1 | Address select: 1 selects command/status, 0 selects data |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Status byte or output buffer, chosen by `host_is_cmd` |
| evt_valid | input | 1 | Event source has a notification code to offer |
| evt_code | input | 8 | Notification code, held while `evt_valid` is high |
| evt_ready | output | 1 | The code is taken at this edge |
| sci | output | 1 | One-cycle host interrupt pulse |

## Verification
Each internal flag appears directly in the status byte. A corrupted burst, input-full, output-full or pending flag therefore shows on a status read in the very cycle after the bad edge. A mis-decoded command shows up one edge after consumption, as a wrong acknowledge byte, an output buffer that stays empty, or a missing `sci` pulse. A fault in the consumption timing shows as an input-full flag that clears early or late, or as an `sci` pulse for a burst-off command that is misplaced relative to the fall of input-full. Dropped writes and ignored commands are checked by watching status and `sci` over the cycles in which a wrongly accepted byte would have acted.

// File: rtl/ec_host_mailbox.sv
module ec_host_mailbox (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_is_cmd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       evt_valid,
  input  logic [7:0] evt_code,
  output logic       evt_ready,
  output logic       sci
);

  localparam logic [7:0] OP_BURST_ON  = 8'h82;
  localparam logic [7:0] OP_BURST_OFF = 8'h83;
  localparam logic [7:0] OP_QUERY     = 8'h84;
  localparam logic [7:0] ACK_BYTE     = 8'h90;
  localparam logic [7:0] NO_EVENT     = 8'h00;

  logic [7:0] ibuf, obuf;
  logic       ibf, obf, cmd_f, burst, pend_evt, taken, off_pend, sci_q;

  wire wr_ok     = host_wr && !ibf;
  wire consume   = ibf && !taken;
  wire op_on     = consume && cmd_f && (ibuf == OP_BURST_ON);
  wire op_off    = consume && cmd_f && (ibuf == OP_BURST_OFF);
  wire op_query  = consume && cmd_f && (ibuf == OP_QUERY);
  wire evt_take  = op_query && pend_evt;
  wire evt_new   = evt_valid && !pend_evt;
  wire ob_load   = op_on || op_query;
  wire ob_drain  = host_rd && !host_is_cmd;
  wire off_done  = taken && off_pend;

  assign evt_ready  = evt_take;
  assign sci        = sci_q;
  assign host_rdata = host_is_cmd ? {2'b00, pend_evt, burst, cmd_f, 1'b0, ibf, obf} : obuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibuf     <= '0;
      obuf     <= '0;
      ibf      <= 1'b0;
      obf      <= 1'b0;
      cmd_f    <= 1'b0;
      burst    <= 1'b0;
      pend_evt <= 1'b0;
      taken    <= 1'b0;
      off_pend <= 1'b0;
      sci_q    <= 1'b0;
    end else begin
      if (wr_ok) begin
        ibuf  <= host_wdata;
        cmd_f <= host_is_cmd;
        ibf   <= 1'b1;
      end else if (taken) begin
        ibf <= 1'b0;
      end

      taken <= consume;

      if (op_off)
        off_pend <= 1'b1;
      else if (off_done)
        off_pend <= 1'b0;

      if (op_on)
        burst <= 1'b1;
      else if (off_done)
        burst <= 1'b0;

      if (op_on)
        obuf <= ACK_BYTE;
      else if (op_query)
        obuf <= pend_evt ? evt_code : NO_EVENT;

      if (ob_load)
        obf <= 1'b1;
      else if (ob_drain)
        obf <= 1'b0;

      if (evt_take)
        pend_evt <= 1'b0;
      else if (evt_new)
        pend_evt <= 1'b1;

      sci_q <= ob_load || off_done || evt_new;
    end
  end

  AST_BURST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    op_on |=> (burst && obf && obuf == ACK_BYTE && sci)); // R1

  AST_BURST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    off_done |=> (!burst && !ibf && sci)); // R2

  AST_IBF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && taken && !host_wr) |=> !ibf); // R3

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && ibf) |=> $stable(ibuf)); // R4

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_drain && !ob_load) |=> !obf); // R5

  AST_EVT_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready |=> (obf && !pend_evt && obuf == $past(evt_code))); // R6

  AST_EVT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !pend_evt) |=> (pend_evt && sci)); // R8

endmodule

// File: tb/ec_host_mailbox_tb.sv
module ec_host_mailbox_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_is_cmd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       evt_valid = 1'b0;
  logic [7:0] evt_code = '0;
  logic       evt_ready, sci;

  int n_checks = 0;
  int n_fails  = 0;

  ec_host_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_is_cmd(host_is_cmd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_ready(evt_ready), .sci(sci)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] peek_status();
    return host_is_cmd ? host_rdata : 8'hxx;
  endfunction

  task automatic get_status(output logic [7:0] s);
    host_is_cmd = 1'b1; #1; s = host_rdata;
  endtask

  task automatic host_write(input bit is_cmd, input logic [7:0] b);
    host_is_cmd = is_cmd; host_wdata = b; host_wr = 1'b1;
    step();
    host_wr = 1'b0; host_is_cmd = 1'b1;
  endtask

  task automatic read_data(output logic [7:0] d);
    host_is_cmd = 1'b0; host_rd = 1'b1; #1; d = host_rdata;
    step();
    host_rd = 1'b0; host_is_cmd = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] s, d;
    get_status(s);
    check(s == 8'h00, "R10 status", s, 0);
    check(sci == 1'b0, "R10 sci", sci, 0);
    host_is_cmd = 1'b0; #1; d = host_rdata; host_is_cmd = 1'b1;
    check(d == 8'h00, "R10 obuf", d, 0);
  endtask

  task automatic t_burst_on();
    logic [7:0] s, d;
    host_write(1'b1, 8'h82);
    get_status(s);
    check(s == 8'h0A, "R3 ibf+cmd after write", s, 8'h0A);
    step(); get_status(s);
    check(s == 8'h1B, "R1 burst+obf status", s, 8'h1B);
    check(sci == 1'b1, "R1 sci pulse", sci, 1);
    step(); get_status(s);
    check(s == 8'h19, "R3 ibf cleared", s, 8'h19);
    check(sci == 1'b0, "R1 sci one cycle", sci, 0);
    read_data(d);
    check(d == 8'h90, "R1 ack byte", d, 8'h90);
    get_status(s);
    check(s[0] == 1'b0, "R5 obf cleared by read", s[0], 0);
    check(s[7:6] == 2'b00 && s[2] == 1'b0, "R5 reserved bits", s, 8'h18);
  endtask

  task automatic t_burst_off_busy();
    logic [7:0] s;
    host_write(1'b1, 8'h83);
    host_write(1'b1, 8'h82);
    get_status(s);
    check(s[4] == 1'b1 && sci == 1'b0, "R2 burst held until ibf falls", s, 8'h1A);
    step(); get_status(s);
    check(s[4] == 1'b0 && s[1] == 1'b0, "R2 burst and ibf clear together", s, 8'h08);
    check(sci == 1'b1, "R2 sci on exit", sci, 1);
    step(); step(); get_status(s);
    check(s == 8'h08, "R4 busy write dropped", s, 8'h08);
  endtask

  task automatic t_data_write();
    logic [7:0] s;
    host_write(1'b0, 8'h82);
    get_status(s);
    check(s == 8'h02, "R3 data write clears cmd bit", s, 8'h02);
    step();
    check(sci == 1'b0, "R9 data byte no sci", sci, 0);
    step(); get_status(s);
    check(s == 8'h00, "R9 data byte no effect", s, 0);
  endtask

  task automatic t_unknown();
    logic [7:0] s, d;
    int sci_seen = 0;
    host_write(1'b1, 8'h82); step(); step(); read_data(d);
    host_write(1'b1, 8'h55);
    for (int i = 0; i < 3; i++) begin
      if (sci) sci_seen++;
      step();
    end
    get_status(s);
    check(s == 8'h18, "R9 unknown cmd keeps burst", s, 8'h18);
    check(sci_seen == 0, "R9 unknown cmd no sci", sci_seen, 0);
    host_is_cmd = 1'b0; #1; d = host_rdata; host_is_cmd = 1'b1;
    check(d == 8'h90, "R9 obuf untouched", d, 8'h90);
    host_write(1'b1, 8'h83); step(); step();
  endtask

  task automatic t_query_event();
    logic [7:0] s, d;
    evt_code = 8'h3C; evt_valid = 1'b1;
    step(); get_status(s);
    check(s[5] == 1'b1, "R8 pending flag", s, 8'h20);
    check(sci == 1'b1, "R8 sci on event", sci, 1);
    step();
    check(sci == 1'b0, "R8 single pulse", sci, 0);
    host_write(1'b1, 8'h84);
    check(evt_ready == 1'b1, "R6 evt_ready", evt_ready, 1);
    step();
    evt_valid = 1'b0;
    get_status(s);
    check(s[5] == 1'b0 && s[0] == 1'b1, "R6 pending cleared, obf set", s, 8'h0B);
    check(sci == 1'b1, "R6 sci on answer", sci, 1);
    step();
    read_data(d);
    check(d == 8'h3C, "R6 code in obuf", d, 8'h3C);
  endtask

  task automatic t_query_none();
    logic [7:0] s, d;
    int rdy_seen = 0;
    host_write(1'b1, 8'h84);
    if (evt_ready) rdy_seen++;
    step();
    get_status(s);
    check(s[0] == 1'b1 && sci == 1'b1, "R7 obf and sci", s, 8'h0B);
    check(rdy_seen == 0, "R7 no evt_ready", rdy_seen, 0);
    step();
    read_data(d);
    check(d == 8'h00, "R7 zero answer", d, 0);
  endtask

  initial begin
    host_is_cmd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst_on();
    t_burst_off_busy();
    t_data_write();
    t_unknown();
    t_query_event();
    t_query_none();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule